// File: doc/BRIEF.md
# Supervisor Countdown Timer with Privileged Reload

This block is a down-counter that hands control back to the supervisor once a programmed interval has run out. Supervisor code writes a start value. The counter then loses one unit on each clock where the tick enable is high. When it runs out, the block raises an interrupt request.

Writing the start value is a privileged operation. A write made while the processor runs in user mode leaves the timer untouched and produces a one-cycle illegal-operation fault pulse.

The interrupt request stays high until it is acknowledged. A further expiry that arrives during service is not dropped. It is held as a single pending event, and the request stays asserted across the acknowledge so that the event is serviced next. The current count can always be read back.

Top module: `priv_timer`

## Requirements
- R1: While running, each cycle with `tick_i` high lowers `count_o` by one in the following cycle. A cycle with `tick_i` low leaves `count_o` unchanged.
- R2: The tick that takes a running count from 1 to 0 also raises `irq_o`. The rise is visible in the same cycle that `count_o` first reads 0.
- R3: The mode encoding is `user_mode_i` = 0 for monitor mode and 1 for user mode. A load in monitor mode puts `load_val_i` on `count_o` in the next cycle and starts the counter. A load wins over a tick in the same cycle.
- R4: A load in user mode has no effect. `count_o` and the running state are unchanged. `fault_o` is high for exactly the next cycle.
- R5: A monitor-mode load of zero raises `irq_o` after the first subsequent tick.
- R6: After expiry the count stays at 0 and the counter stops. Further ticks neither wrap the count nor raise another expiry until a new load.
- R7: `irq_o` stays high until `ack_i` is sampled high. An `ack_i` while `irq_o` is low has no effect.
- R8: An expiry while `irq_o` is already high is recorded as one pending event. The next acknowledge keeps `irq_o` high, and the acknowledge after that clears it. Further expiries while an event is pending are merged into it.
- R9: After reset `count_o` is 0, and `irq_o` and `fault_o` are low. Ticks have no effect until the first accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_mode_i | input | 1 | Current mode bit: 0 monitor, 1 user |
| load_i | input | 1 | Request to load a new count |
| load_val_i | input | CNT_W | Count value carried by the load |
| tick_i | input | 1 | Tick enable for counting down |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Timer interrupt request |
| count_o | output | CNT_W | Current count |
| fault_o | output | 1 | Illegal-operation fault pulse for a user-mode load |

## Verification
The assertions assume that every control input is a known 0 or 1 on each rising edge. They also assume that a load and its mode bit are presented together in one cycle. In addition, they assume that `ack_i` answers a request the block has actually raised, or else is harmlessly idle.

The stimulus changes all inputs only on the falling clock edge, and always drives them to defined values. The acknowledges it issues include some with no request outstanding, so the ignored case is covered. User-mode loads are mixed with ticks to cover the case where a rejected load and counting fall in the same cycle.

// File: rtl/priv_timer_pkg.sv
package priv_timer_pkg;

    // Number of timer events awaiting service (request + one pending slot)
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_TWO  = 2'd2
    } irq_lvl_e;

    typedef struct packed {
        logic fault;
    } gate_state_t;

    typedef struct packed {
        irq_lvl_e lvl;
    } irq_state_t;

endpackage

// File: rtl/priv_timer_load_gate.sv
module priv_timer_load_gate
    import priv_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic user_mode_i,
    input  logic load_i,
    output logic accept_o,
    output logic fault_o
);

    gate_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        accept_o   = load_i && !user_mode_i;
        st_d.fault = load_i && user_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o = st_q.fault;

    AST_USER_LOAD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && user_mode_i) |=> fault_o) else $error("user load without fault"); // R4

    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !(load_i && user_mode_i)) |=> !fault_o) else $error("fault stuck"); // R4

endmodule

// File: rtl/priv_timer_counter.sv
module priv_timer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (accept_i) begin
            st_d.count   = load_val_i;
            st_d.running = 1'b1;
        end else if (st_q.running && tick_i) begin
            if (st_q.count <= CNT_ONE) begin
                st_d.count   = '0;
                st_d.running = 1'b0;
                expire_o     = 1'b1;
            end else begin
                st_d.count = st_q.count - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> (count_o == $past(load_val_i))) else $error("load lost"); // R3

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && tick_i && st_q.running && count_o > CNT_ONE)
        |=> (count_o == $past(count_o) - CNT_ONE)) else $error("bad decrement"); // R1

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !tick_i) |=> $stable(count_o)) else $error("count moved"); // R1

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && count_o == '0) |=> (count_o == '0)) else $error("count wrapped"); // R6

    AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (count_o == '0 && !st_q.running)) else $error("expiry state"); // R2

endmodule

// File: rtl/priv_timer_irq_track.sv
module priv_timer_irq_track
    import priv_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic ack_i,
    output logic irq_o
);

    irq_state_t st_d, st_q;
    logic       serviced;

    always_comb begin
        st_d     = st_q;
        serviced = ack_i && (st_q.lvl != LVL_NONE);
        unique case ({serviced, expire_i})
            2'b10:   st_d.lvl = (st_q.lvl == LVL_TWO) ? LVL_ONE : LVL_NONE;
            2'b01:   st_d.lvl = (st_q.lvl == LVL_NONE) ? LVL_ONE : LVL_TWO;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.lvl <= LVL_NONE;
        else        st_q     <= st_d;
    end

    assign irq_o = (st_q.lvl != LVL_NONE);

    AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> irq_o) else $error("expiry not signalled"); // R2

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o) else $error("request dropped"); // R7

    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !expire_i) |=> !irq_o) else $error("spurious request"); // R7

    AST_PENDING_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl == LVL_TWO && ack_i) |=> irq_o) else $error("pending lost"); // R8

endmodule

// File: rtl/priv_timer.sv
module priv_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [CNT_W-1:0] count_o,
    output logic             fault_o
);

    logic accept;
    logic expire;

    priv_timer_load_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .user_mode_i (user_mode_i),
        .load_i      (load_i),
        .accept_o    (accept),
        .fault_o     (fault_o)
    );

    priv_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .load_val_i (load_val_i),
        .tick_i     (tick_i),
        .count_o    (count_o),
        .expire_o   (expire)
    );

    priv_timer_irq_track u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .ack_i    (ack_i),
        .irq_o    (irq_o)
    );

    AST_USER_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && user_mode_i && !tick_i) |=> $stable(count_o)) else $error("user load applied"); // R4

endmodule

// File: tb/priv_timer_bench.sv
module priv_timer_bench;

    localparam int  CNT_W  = 8;
    localparam time PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             user_mode_i = 1'b0;
    logic             load_i = 1'b0;
    logic [CNT_W-1:0] load_val_i = '0;
    logic             tick_i = 1'b0;
    logic             ack_i = 1'b0;
    logic             irq_o;
    logic [CNT_W-1:0] count_o;
    logic             fault_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [CNT_W-1:0] q_cnt[$];
    logic             q_irq[$];
    logic             q_flt[$];
    string            q_tag[$];

    logic [CNT_W-1:0] m_cnt = '0;
    logic             m_run = 1'b0;
    int               m_lvl = 0;

    always #(PERIOD/2) clk = ~clk;

    priv_timer #(.CNT_W(CNT_W)) u_priv_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .user_mode_i (user_mode_i),
        .load_i      (load_i),
        .load_val_i  (load_val_i),
        .tick_i      (tick_i),
        .ack_i       (ack_i),
        .irq_o       (irq_o),
        .count_o     (count_o),
        .fault_o     (fault_o)
    );

    // Driver: one cycle of stimulus plus the expected outcome after the next edge
    task automatic step(input logic ld, input logic [CNT_W-1:0] v, input logic usr,
                        input logic tk, input logic ak, input string tag);
        logic acc, exp;
        @(negedge clk);
        load_i = ld; load_val_i = v; user_mode_i = usr; tick_i = tk; ack_i = ak;
        acc = ld && !usr;
        exp = !acc && m_run && tk && (m_cnt <= 1);
        if (acc) begin
            m_cnt = v; m_run = 1'b1;
        end else if (m_run && tk) begin
            if (m_cnt <= 1) begin m_cnt = '0; m_run = 1'b0; end
            else m_cnt = m_cnt - 1'b1;
        end
        if (ak && m_lvl != 0) m_lvl = m_lvl - 1;
        if (exp) m_lvl = (m_lvl >= 2) ? 2 : m_lvl + 1;
        q_cnt.push_back(m_cnt);
        q_irq.push_back(m_lvl != 0);
        q_flt.push_back(ld && usr);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (q_cnt.size() > 0) begin
            logic [CNT_W-1:0] ec;
            logic ei, ef;
            string t;
            ec = q_cnt.pop_front(); ei = q_irq.pop_front();
            ef = q_flt.pop_front(); t = q_tag.pop_front();
            checks++;
            if (count_o !== ec || irq_o !== ei || fault_o !== ef) begin
                errors++;
                $display("FAIL %s: count/irq/fault = %0d/%0b/%0b expected %0d/%0b/%0b",
                         t, count_o, irq_o, fault_o, ec, ei, ef);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R9 reset state");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R9 ticks before load");
        step(1, 8'd5, 0, 0, 0, "R3 monitor load");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R1 countdown");
        step(0, 0, 0, 1, 0, "R2 expiry raises irq");
        step(0, 0, 0, 1, 0, "R6 stop at zero");
        step(0, 0, 0, 1, 0, "R6 no second expiry");
        step(0, 0, 0, 0, 0, "R7 held without ack");
        step(0, 0, 0, 0, 1, "R7 ack clears");
        step(0, 0, 0, 0, 1, "R7 idle ack ignored");
        step(1, 8'd9, 1, 0, 0, "R4 user load ignored");
        step(0, 0, 0, 0, 0, "R4 fault one cycle");
        step(1, 8'd3, 0, 1, 0, "R3 load beats tick");
        step(0, 0, 0, 0, 0, "R1 no tick hold");
        step(1, 8'd7, 1, 1, 0, "R4 user load with tick");
        step(0, 0, 0, 1, 0, "R1 countdown after rejected load");
        step(1, 8'd0, 0, 0, 0, "R5 load zero");
        step(0, 0, 0, 0, 0, "R5 no tick no irq");
        step(0, 0, 0, 1, 0, "R5 first tick raises");
        step(1, 8'd2, 0, 0, 0, "R8 reload during service");
        step(0, 0, 0, 1, 0, "R8 count");
        step(0, 0, 0, 1, 0, "R8 second expiry pending");
        step(0, 0, 0, 0, 1, "R8 ack re-raises");
        step(0, 0, 0, 0, 1, "R8 final ack clears");
        step(1, 8'd1, 0, 0, 0, "R8 load one");
        step(0, 0, 0, 1, 0, "R8 first");
        step(1, 8'd1, 0, 0, 0, "R8 load one");
        step(0, 0, 0, 1, 0, "R8 pending");
        step(1, 8'd1, 0, 0, 0, "R8 load one");
        step(0, 0, 0, 1, 0, "R8 merged");
        step(0, 0, 0, 0, 1, "R8 ack one");
        step(0, 0, 0, 0, 1, "R8 ack two clears");
        step(1, 8'd1, 0, 0, 0, "R7 load one");
        step(0, 0, 0, 1, 1, "R7 idle ack with expiry");
        step(0, 0, 0, 0, 1, "R7 ack clears");
        step(0, 0, 0, 0, 0, "R9 idle");
        repeat (3) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule